// File: doc/BRIEF.md
# Push-Button Output Voltage Selector

Two push buttons move a selection through six fixed output-voltage levels: 3.0, 4.5, 5.0, 6.0, 7.5 and 9.0 V. The selection is held as a one-hot 6-bit word, and that word drives one LED per level. The same word picks an 8-bit regulation setpoint code from a small table of parameter constants. The block runs on a periodic control-loop tick. Each button has its own hold counter, and that counter advances only on ticks where the button is pressed.

A step happens when a counter overflows. The down button moves the lit bit one place toward bit 0, which is the 3.0 V level. The up button moves it one place toward bit 5, which is the 9.0 V level. Neither button moves the bit past its end. After any step both hold counters reload their preload value. With the default preload and a tick rate of about 4.9 kHz, a button held down gives one step about every half second. If both counters overflow on the same tick, the down step is applied first and the up step is applied to the result.

Top module: `setpt_selector`

## Requirements
- R1: After reset, `led_o` is 6'b000001 (bit 0 = 3.0 V) and `setpt_o` holds table entry 0. Both hold counters start at PRELOAD.
- R2: Exactly one bit of `led_o` is set at all times. Bit k stands for level k, in the order 3.0, 4.5, 5.0, 6.0, 7.5, 9.0 V.
- R3: When the down counter overflows, `led_o` shifts right by one bit. If bit 0 is already set, `led_o` is left unchanged.
- R4: When the up counter overflows, `led_o` shifts left by one bit. If bit 5 is already set, `led_o` is left unchanged.
- R5: A counter counts only on ticks where its button is pressed. Counting up from PRELOAD, it overflows on the (2^CNT_W − PRELOAD)-th such tick. A released button's counter holds its value.
- R6: Any overflow reloads both counters to PRELOAD. This also happens when the step is blocked at an end.
- R7: If both counters overflow on the same tick, the down step is applied first and the up step uses the updated word. Result: a middle level stays where it is, level 0 moves to level 1, and level 5 stays at level 5.
- R8: `setpt_o` equals table entry k when bit k of `led_o` is lit. It changes on the same clock edge as `led_o`.
- R9: When no overflow occurs, and in particular on any cycle without a tick, `led_o` and `setpt_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Control-loop tick, one cycle wide |
| up_i | input | 1 | Up button, high while pressed |
| dn_i | input | 1 | Down button, high while pressed |
| led_o | output | 6 | One-hot level indicator |
| setpt_o | output | 8 | Setpoint code for the selected level |

## Verification
Only one register stage lies between the overflow and the outputs. A step is therefore visible on `led_o` and `setpt_o` at the clock edge that samples the overflowing tick, with no extra latency. The bench raises `tick_i` for exactly one cycle at a falling edge and checks both outputs at the next falling edge, half a cycle after the update. It sets PRELOAD so that a step needs four held ticks. Each check is placed one tick before and one tick after the expected step, so a step that comes early or late by one tick is caught.

// File: rtl/setpt_sel_pkg.sv
package setpt_sel_pkg;
  localparam int unsigned NUM_LVL = 6;
  localparam int unsigned SP_W    = 8;
  typedef logic [NUM_LVL-1:0] lvl_t;
  typedef logic [SP_W-1:0]    sp_t;
endpackage

// File: rtl/btn_hold_cnt.sv
module btn_hold_cnt #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRELOAD = 63095
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             btn_i,
  input  logic             clr_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] PRE_V = CNT_W'(PRELOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv   = tick_i & btn_i;
  assign ovf_o = adv & (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= PRE_V;
    else if (clr_i)  cnt_q <= PRE_V;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end

  // R5: idle counter keeps its value
  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lvl_shifter.sv
module lvl_shifter
  import setpt_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dn_step_i,
  input  logic up_step_i,
  output lvl_t led_o
);
  lvl_t led_q, mid, nxt;

  // down first, up acts on the result
  always_comb begin
    mid = (dn_step_i && !led_q[0]) ? (led_q >> 1) : led_q;
    nxt = (up_step_i && !mid[NUM_LVL-1]) ? (mid << 1) : mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_q <= lvl_t'(1);
    else         led_q <= nxt;
  end

  assign led_o = led_q;

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(led_q) == 1);
  a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_step_i && !up_step_i && led_q[0]) |=> led_q[0]);
  a_r4_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_step_i && !dn_step_i && led_q[NUM_LVL-1]) |=> led_q[NUM_LVL-1]);
  a_r7_both_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_step_i && up_step_i && !led_q[0]) |=> $stable(led_q));
  a_r9_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_step_i && !up_step_i) |=> $stable(led_q));
endmodule

// File: rtl/setpt_lut.sv
module setpt_lut
  import setpt_sel_pkg::*;
#(
  parameter logic [NUM_LVL*SP_W-1:0] SP_TABLE = '0
) (
  input  lvl_t sel_i,
  output sp_t  setpt_o
);
  sp_t term [NUM_LVL];

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_term
    assign term[i] = {SP_W{sel_i[i]}} & SP_TABLE[i*SP_W +: SP_W];
  end

  always_comb begin
    setpt_o = '0;
    for (int i = 0; i < NUM_LVL; i++) setpt_o = setpt_o | term[i];
  end
endmodule

// File: rtl/setpt_selector.sv
module setpt_selector
  import setpt_sel_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRELOAD = 63095,
  parameter logic [NUM_LVL*SP_W-1:0] SP_TABLE =
    {8'hE6, 8'hBF, 8'h99, 8'h80, 8'h73, 8'h4D}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       up_i,
  input  logic       dn_i,
  output logic [5:0] led_o,
  output logic [7:0] setpt_o
);
  localparam logic [CNT_W-1:0] PRE_V = CNT_W'(PRELOAD);

  logic             dn_ovf, up_ovf, clr;
  logic [CNT_W-1:0] dn_cnt, up_cnt;
  lvl_t             led;

  assign clr = dn_ovf | up_ovf;

  btn_hold_cnt #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_dn_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .btn_i(dn_i),
    .clr_i(clr), .ovf_o(dn_ovf), .cnt_o(dn_cnt)
  );

  btn_hold_cnt #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_up_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .btn_i(up_i),
    .clr_i(clr), .ovf_o(up_ovf), .cnt_o(up_cnt)
  );

  lvl_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dn_step_i(dn_ovf), .up_step_i(up_ovf), .led_o(led)
  );

  setpt_lut #(.SP_TABLE(SP_TABLE)) u_lut (
    .sel_i(led), .setpt_o(setpt_o)
  );

  assign led_o = led;

  a_r6_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_ovf || up_ovf) |=> (dn_cnt == PRE_V && up_cnt == PRE_V));
  a_r9_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(led_o) && $stable(setpt_o)));
endmodule

// File: tb/setpt_selector_tb.sv
`timescale 1ns/1ps
module setpt_selector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, up = 1'b0, dn = 1'b0;
  logic [5:0] led;
  logic [7:0] sp;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  logic [7:0] exp_sp [6] = '{8'h4D, 8'h73, 8'h80, 8'h99, 8'hBF, 8'hE6};

  always #4 clk = ~clk;

  // 2^16 - 65532 = 4 held ticks per step
  setpt_selector #(.CNT_W(16), .PRELOAD(65532)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .up_i(up), .dn_i(dn),
    .led_o(led), .setpt_o(sp)
  );

  task automatic check(input int idx, input string tag);
    logic [5:0] el;
    el = 6'b1 << idx;
    n_chk++;
    if (led !== el || sp !== exp_sp[idx]) begin
      n_fail++;
      $display("FAIL %s: led=%b sp=%h expected led=%b sp=%h", tag, led, sp, el, exp_sp[idx]);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check(0, "R1 reset state");
  endtask

  task automatic t_down_floor();
    dn = 1'b1; ticks(4); check(0, "R3 down saturates at bit 0"); dn = 1'b0;
  endtask

  task automatic t_up_walk();
    up = 1'b1;
    ticks(3); check(0, "R5 no step before 4th tick");
    ticks(1); check(1, "R4 up step / R8 setpoint");
    ticks(4); check(2, "R4 second up step");
    ticks(12); check(5, "R4 reach top R2");
    ticks(4); check(5, "R4 up saturates at bit 5");
    up = 1'b0;
  endtask

  task automatic t_no_tick();
    dn = 1'b1;
    repeat (20) @(negedge clk);
    check(5, "R9 no change without tick");
    ticks(3); check(5, "R5 counts ticks only");
    ticks(1); check(4, "R3 down step");
    dn = 1'b0;
  endtask

  task automatic t_release();
    dn = 1'b1; ticks(2);
    dn = 1'b0; ticks(2); check(4, "R5 released counter holds");
    dn = 1'b1; ticks(1); check(4, "R5 third held tick");
    ticks(1); check(3, "R5 step on fourth held tick");
    dn = 1'b0;
  endtask

  task automatic t_clear_both();
    up = 1'b1; ticks(2); up = 1'b0;
    dn = 1'b1; ticks(4); check(2, "R6 down step while up partly counted");
    dn = 1'b0;
    up = 1'b1; ticks(2); check(2, "R6 up counter was reloaded");
    ticks(2); check(3, "R6 up step after full count");
    up = 1'b0;
  endtask

  task automatic t_both();
    up = 1'b1; dn = 1'b1; ticks(4); check(3, "R7 both in middle net zero");
    up = 1'b0; ticks(12); check(0, "R3 walk to bottom");
    up = 1'b1; ticks(4); check(1, "R7 both at bottom moves up");
    dn = 1'b0; ticks(16); check(5, "R4 walk to top");
    dn = 1'b1; ticks(4); check(5, "R7 both at top stays");
    up = 1'b0; dn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down_floor();
    t_up_walk();
    t_no_tick();
    t_release();
    t_clear_both();
    t_both();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule